// File: doc/BRIEF.md
# Single-Bit Input Port with Rising-Edge Interrupt

This block lets software observe one asynchronous input line, such as a push button or a switch, through a small register window on a simple register bus. The bus has an address, separate read and write strobes, write data and read data. The pin passes through a synchronizer. Its settled level can be read from a read-only status word.

A read/write enable bit arms an interrupt. A rising transition of the synchronized input, seen while the enable bit is 1, latches a level interrupt output. That output stays high until software writes 0 to the enable bit, or until reset. There is no separate acknowledge register: software clears the interrupt by disabling it and re-arms it by enabling it again.

The window is 16 bytes wide and is decoded on the full 4-bit byte address. Read data is combinational. It is valid in the same cycle as the read strobe and is zero whenever the read strobe is low.

Top module: `edge_in_port`

## Requirements
- R1: Byte offset 0x0 holds the level word. Bit 0 reads as the pin level after a two-flop synchronizer. A pin change driven before a clock edge is visible on a read after the second following rising edge, and not after the first.
- R2: The level word at offset 0x0 is read-only. A write there changes neither the enable bit nor the interrupt output.
- R3: Byte offset 0x8 holds the enable bit in bit 0. A write stores write-data bit 0, and a read returns the stored value.
- R4: With the enable bit at 1, a 0-to-1 transition of the pin raises irqOut after the third rising clock edge following the pin change.
- R5: A rising transition that happens while the enable bit is 0 is discarded. Setting the enable bit afterwards does not raise irqOut.
- R6: Once raised, irqOut stays high while the enable bit stays 1. This holds when the pin falls and when 1 is rewritten to the enable bit.
- R7: Writing 0 to the enable bit drops irqOut at the clock edge that takes the write.
- R8: Only a new 0-to-1 transition raises irqOut. A pin held high, or a falling transition, raises nothing.
- R9: Offsets 0x4 and 0xC read as zero, and writes to them have no effect. Bits 31:1 of every read are zero.
- R10: Reset (rstN low, asynchronous) clears the enable bit, irqOut and the synchronizer stages, so the level word reads 0 right after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Byte address within the window |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, combinational, zero when rdEn is low |
| pinIn | input | 1 | Asynchronous input line |
| irqOut | output | 1 | Level interrupt request |

## Verification
The bench targets the edge arming rule. A rising transition taken while the enable bit is 0, and then followed by enabling, must not raise the interrupt; a design that only compared the current level would fire there. A pin held high across a disable/enable cycle must stay quiet too. The bench counts edges to the exact cycle, so an extra or a missing synchronizer stage shows up as the level or the interrupt arriving one edge early or late. It writes 1 again to the enable bit and writes to the level word and to the unused offsets while an interrupt is pending, which catches decodes that clear the interrupt on any write. It also asserts reset with the pin high and reads straight after release, which catches synchronizer stages that reset does not clear.

// File: rtl/edge_in_pkg.sv
package edge_in_pkg;

  // Strobes from the bus decode to the datapath
  typedef struct packed {
    logic maskWr;   // write to the enable register this cycle
    logic maskVal;  // value carried by that write
    logic selData;  // read of the level word
    logic selMask;  // read of the enable word
  } ctlStrobes_t;

endpackage

// File: rtl/edge_in_ctrl.sv
module edge_in_ctrl
  import edge_in_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_OFS = 0,
  parameter int MASK_OFS = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic              wrBit0,
  output ctlStrobes_t       ctl
);

  localparam logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(DATA_OFS);
  localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(MASK_OFS);

  logic hitData;
  logic hitMask;

  always_comb begin
    hitData = (addr == DATA_ADDR);
    hitMask = (addr == MASK_ADDR);
  end

  // Writes to the level word and to unused offsets produce no strobe
  always_comb begin
    ctl.maskWr  = wrEn & hitMask;
    ctl.maskVal = wrBit0;
    ctl.selData = rdEn & hitData;
    ctl.selMask = rdEn & hitMask;
  end

endmodule

// File: rtl/edge_in_dpath.sv
module edge_in_dpath
  import edge_in_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pinIn,
  input  ctlStrobes_t       ctl,
  output logic              syncLevel,
  output logic              maskBit,
  output logic              irqOut,
  output logic [DATA_W-1:0] rdData
);

  localparam int PAD_W = DATA_W - 1;

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   prevLevel;
  logic                   riseSeen;

  // Synchronizer chain, cleared by reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain <= '0;
    else       syncChain <= {syncChain[SYNC_STAGES-2:0], pinIn};
  end

  assign syncLevel = syncChain[SYNC_STAGES-1];

  // Edge detector on the settled level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLevel <= 1'b0;
    else       prevLevel <= syncLevel;
  end

  assign riseSeen = syncLevel & ~prevLevel;

  // Enable register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           maskBit <= 1'b0;
    else if (ctl.maskWr) maskBit <= ctl.maskVal;
  end

  // Pending interrupt: a disabling write wins over a same-cycle edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          irqOut <= 1'b0;
    else if (ctl.maskWr && !ctl.maskVal) irqOut <= 1'b0;
    else if (maskBit && riseSeen)        irqOut <= 1'b1;
  end

  // Read mux, upper bits always zero
  always_comb begin
    rdData = '0;
    if (ctl.selData)      rdData = {{PAD_W{1'b0}}, syncLevel};
    else if (ctl.selMask) rdData = {{PAD_W{1'b0}}, maskBit};
  end

endmodule

// File: rtl/edge_in_port.sv
module edge_in_port
  import edge_in_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_OFS    = 0,
  parameter int MASK_OFS    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              pinIn,
  output logic              irqOut
);

  ctlStrobes_t ctl;
  logic        syncLevel;
  logic        maskBit;
  logic        unusedWrBits;

  assign unusedWrBits = ^wrData[DATA_W-1:1];

  edge_in_ctrl #(
    .ADDR_W  (ADDR_W),
    .DATA_OFS(DATA_OFS),
    .MASK_OFS(MASK_OFS)
  ) i_ctrl (
    .addr  (addr),
    .rdEn  (rdEn),
    .wrEn  (wrEn),
    .wrBit0(wrData[0]),
    .ctl   (ctl)
  );

  edge_in_dpath #(
    .DATA_W     (DATA_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .pinIn    (pinIn),
    .ctl      (ctl),
    .syncLevel(syncLevel),
    .maskBit  (maskBit),
    .irqOut   (irqOut),
    .rdData   (rdData)
  );

endmodule

// File: rtl/edge_in_chk.sv
module edge_in_chk #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int DATA_OFS = 0,
  parameter int MASK_OFS = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              rdEn,
  input logic              wrEn,
  input logic              wrBit0,
  input logic [DATA_W-1:0] rdData,
  input logic              maskBit,
  input logic              irqOut
);

  localparam logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(DATA_OFS);
  localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(MASK_OFS);

  logic clearWr;
  logic otherWr;
  logic unusedRd;

  assign clearWr  = wrEn && (addr == MASK_ADDR) && !wrBit0;
  assign otherWr  = wrEn && (addr != MASK_ADDR);
  assign unusedRd = rdEn && (addr != DATA_ADDR) && (addr != MASK_ADDR);

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> maskBit); // R5

  AST_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    clearWr |=> !irqOut); // R7

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !clearWr) |=> irqOut); // R6

  AST_IRQ_RISE_ARMED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(maskBit)); // R5

  AST_OTHER_WRITE_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rstN)
    otherWr |=> $stable(maskBit)); // R2

  AST_UNUSED_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    unusedRd |-> (rdData == '0)); // R9

  AST_UPPER_BITS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rdData[DATA_W-1:1] == '0); // R9

endmodule

bind edge_in_port edge_in_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .DATA_OFS(DATA_OFS),
  .MASK_OFS(MASK_OFS)
) i_edge_in_chk (
  .clk    (clk),
  .rstN   (rstN),
  .addr   (addr),
  .rdEn   (rdEn),
  .wrEn   (wrEn),
  .wrBit0 (wrData[0]),
  .rdData (rdData),
  .maskBit(maskBit),
  .irqOut (irqOut)
);

// File: tb/test_edge_in_port.sv
module test_edge_in_port;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  addr = '0;
  logic        rdEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        pinIn = 1'b0;
  logic        irqOut;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_in_port i_edge_in_port (
    .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .pinIn(pinIn), .irqOut(irqOut)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #1 d = rdData;
    rdEn = 1'b0;
  endtask

  task automatic setPin(input logic v);
    @(negedge clk);
    pinIn = v;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R10", "irq in reset", {31'b0, irqOut}, 32'h0);
    @(negedge clk); rstN = 1'b1;
    busRead(4'h0, d); check("R10", "level after reset", d, 32'h0);
    busRead(4'h8, d); check("R10", "enable after reset", d, 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    setPin(1'b1);
    @(posedge clk); @(negedge clk); addr = 4'h0; rdEn = 1'b1; #1 d = rdData; rdEn = 1'b0;
    check("R1", "level after one edge", d, 32'h0);
    @(posedge clk); @(negedge clk); addr = 4'h0; rdEn = 1'b1; #1 d = rdData; rdEn = 1'b0;
    check("R1", "level after two edges", d, 32'h1);
    setPin(1'b0); edges(3);
    busRead(4'h0, d); check("R1", "level low again", d, 32'h0);
  endtask

  task automatic t_maskRw();
    logic [31:0] d;
    busWrite(4'h8, 32'h1); busRead(4'h8, d); check("R3", "enable set", d, 32'h1);
    busWrite(4'h8, 32'hFFFF_FFFE); busRead(4'h8, d); check("R3", "enable cleared", d, 32'h0);
    busWrite(4'h8, 32'hFFFF_FFFF); busRead(4'h8, d); check("R9", "upper bits zero", d, 32'h1);
  endtask

  task automatic t_edgeIrq();
    setPin(1'b1);
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R4", "irq before third edge", {31'b0, irqOut}, 32'h0);
    @(posedge clk); @(negedge clk);
    check("R4", "irq after third edge", {31'b0, irqOut}, 32'h1);
  endtask

  task automatic t_sticky();
    setPin(1'b0); edges(4);
    check("R6", "irq after pin fell", {31'b0, irqOut}, 32'h1);
    busWrite(4'h8, 32'h1); edges(1);
    check("R6", "irq after rewrite of 1", {31'b0, irqOut}, 32'h1);
  endtask

  task automatic t_writesIgnored();
    logic [31:0] d;
    busWrite(4'h0, 32'h0);
    check("R2", "irq after level write", {31'b0, irqOut}, 32'h1);
    busRead(4'h8, d); check("R2", "enable after level write", d, 32'h1);
    busWrite(4'h4, 32'h0); busWrite(4'hC, 32'h0);
    check("R9", "irq after unused writes", {31'b0, irqOut}, 32'h1);
    busRead(4'h8, d); check("R9", "enable after unused writes", d, 32'h1);
  endtask

  task automatic t_clear();
    busWrite(4'h8, 32'h0);
    check("R7", "irq after disable", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic t_maskedEdge();
    setPin(1'b1); edges(5);
    check("R5", "irq on masked edge", {31'b0, irqOut}, 32'h0);
    busWrite(4'h8, 32'h1); edges(5);
    check("R5", "irq after late enable", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic t_noRetrigger();
    logic [31:0] d;
    busRead(4'h4, d); check("R9", "read 0x4 with pin high", d, 32'h0);
    busRead(4'hC, d); check("R9", "read 0xC with pin high", d, 32'h0);
    setPin(1'b0); edges(5);
    check("R8", "irq on falling edge", {31'b0, irqOut}, 32'h0);
    setPin(1'b1); edges(4);
    check("R8", "irq on new rise", {31'b0, irqOut}, 32'h1);
  endtask

  task automatic t_resetMid();
    logic [31:0] d;
    @(negedge clk); rstN = 1'b0; #1;
    check("R10", "irq during reset", {31'b0, irqOut}, 32'h0);
    @(negedge clk); rstN = 1'b1;
    addr = 4'h0; rdEn = 1'b1; #1 d = rdData; rdEn = 1'b0;
    check("R10", "level right after release", d, 32'h0);
    busRead(4'h8, d); check("R10", "enable after mid reset", d, 32'h0);
    edges(5);
    check("R10", "no irq after release with pin high", {31'b0, irqOut}, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_level();
    t_maskRw();
    t_edgeIrq();
    t_sticky();
    t_writesIgnored();
    t_clear();
    t_maskedEdge();
    t_noRetrigger();
    t_resetMid();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule